// File: doc/BRIEF.md
# CPU core power-up sequencer

This block wakes a secondary processor core from power collapse without software pacing each step. A one-cycle `start` pulse makes it issue a write strobe and the supply-enable code 0xA4 to the voltage controller. It then steps a 9-bit power-control word through a fixed order of clamp and reset releases. It finishes by raising the core-powered-up bit and pulsing `done`.

Every minimum delay is given in nanoseconds as a parameter. Each one becomes a clock-cycle count, rounded up, from the `CLK_HZ` parameter, so changing the clock frequency never makes any wait too short. Between the first write of the word and the last, the bits are released one at a time.

Top module: `core_wake_seq`

## Requirements
- R1: While `rst` is high, and after it is released with no start, `pwr_ctl_o` is 0 and `rail_wr_o`, `busy_o` and `done_o` are all low.
- R2: A `start` sampled high while idle produces, at that same clock edge, a one-cycle `rail_wr_o` pulse with `rail_cmd_o` = 0xA4, and sets `busy_o` high.
- R3: `pwr_ctl_o` first takes the value 0x109 (bits 8, 3 and 0 set) W_RAIL cycles after the rail strobe edge. W_RAIL is the cycle count for 512 us.
- R4: Exactly one cycle after 0x109, `pwr_ctl_o` becomes 0x101, which clears bit 3 (L2 sleep).
- R5: W_L2 cycles (300 ns) after 0x101, `pwr_ctl_o` becomes 0x121, which sets bit 5 (power-on reset).
- R6: W_POR cycles (2 us) after 0x121, `pwr_ctl_o` becomes 0x120, which clears bit 0 (I/O clamp).
- R7: W_CLAMP cycles (2 us) after 0x120, `pwr_ctl_o` becomes 0x100, which clears bit 5.
- R8: W_SETTLE cycles (100 us) after 0x100, `pwr_ctl_o` becomes 0x180 (bit 7 is core-powered-up), and `done_o` is high in that same cycle.
- R9: After the first write of a run, each change of `pwr_ctl_o` flips exactly one bit. Bit 4 (core reset) is never set. Bit 8 (PLL clamp) is set in every nonzero value.
- R10: `done_o` lasts one cycle and `busy_o` is low in that cycle. `busy_o` is high from the strobe cycle until the cycle before `done_o`.
- R11: A `start` sampled while `busy_o` is high is ignored: no new strobe, and the timing of the run does not change.
- R12: Each wait equals ceil(t_ns * CLK_HZ / 1e9) cycles, with a minimum of 1. At 50 MHz the waits are 25600, 15, 100, 100 and 5000 cycles.
- R13: After `done_o`, a new `start` runs the whole sequence again. `pwr_ctl_o` keeps 0x180 until 0x109 is written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Request to power up the core |
| rail_cmd_o | output | 8 | Command value for the voltage controller |
| rail_wr_o | output | 1 | One-cycle write strobe for `rail_cmd_o` |
| pwr_ctl_o | output | 9 | Per-core power-control word |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse when the core is powered up |

## Verification
The rail strobe and `busy_o` are due at the first clock edge that samples `start` high. Each power-control value is due a fixed number of edges after the previous event: W_RAIL after the strobe, then 1, W_L2, W_POR, W_CLAMP and W_SETTLE. `done_o` arrives together with the final value. The bench keeps a behavioural model that counts the same edges and compares every output at the falling edge, half a cycle after each update. A separate monitor measures the cycle distance between changes and checks it against the rounded-up wait constants.

// File: rtl/core_wake_pkg.sv
package core_wake_pkg;

    localparam int PWR_W   = 9;
    localparam int RAIL_W  = 8;
    localparam int N_STEPS = 6;
    localparam int STEP_W  = $clog2(N_STEPS);

    // bit positions in the power-control word
    localparam int B_PLL_CLAMP = 8;
    localparam int B_CORE_UP   = 7;
    localparam int B_POR       = 5;
    localparam int B_CORE_RST  = 4;
    localparam int B_L2_SLEEP  = 3;
    localparam int B_IO_CLAMP  = 0;

    typedef enum logic {
        WK_IDLE = 1'b0,
        WK_RUN  = 1'b1
    } wk_state_e;

    typedef struct packed {
        wk_state_e          st;
        logic [STEP_W-1:0]  step;
        logic [PWR_W-1:0]   pwr;
        logic [RAIL_W-1:0]  rail;
        logic               rail_wr;
        logic               busy;
        logic               done;
    } wk_regs_t;

    // rounded-up conversion of a delay to clock cycles, never below one
    function automatic longint unsigned ns_to_cycles(longint unsigned ns,
                                                      longint unsigned hz);
        longint unsigned c;
        c = (ns * hz + 64'd999_999_999) / 64'd1_000_000_000;
        if (c == 0) c = 1;
        return c;
    endfunction

    function automatic int unsigned max_of(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/wake_delay_timer.sv
module wake_delay_timer
    import core_wake_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [CNT_W-1:0] len_i,
    output logic             expire_o
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = len_i;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    // final cycle of a loaded interval
    assign expire_o = (cnt_q == CNT_W'(1));

    a_r12_countdown: assert property (@(posedge clk) disable iff (rst)
        (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CNT_W'(1)));

    a_r12_load: assert property (@(posedge clk) disable iff (rst)
        load_i |=> (cnt_q == $past(len_i)));

endmodule

// File: rtl/wake_step_table.sv
module wake_step_table
    import core_wake_pkg::*;
#(
    parameter int unsigned W_L2     = 1,
    parameter int unsigned W_POR    = 1,
    parameter int unsigned W_CLAMP  = 1,
    parameter int unsigned W_SETTLE = 1,
    parameter int          CNT_W    = 16
) (
    input  logic [STEP_W-1:0] idx_i,
    output logic [PWR_W-1:0]  pwr_o,
    output logic [CNT_W-1:0]  wait_o,
    output logic              last_o
);

    localparam logic [PWR_W-1:0] M_PLL  = PWR_W'(1) << B_PLL_CLAMP;
    localparam logic [PWR_W-1:0] M_UP   = PWR_W'(1) << B_CORE_UP;
    localparam logic [PWR_W-1:0] M_POR  = PWR_W'(1) << B_POR;
    localparam logic [PWR_W-1:0] M_L2   = PWR_W'(1) << B_L2_SLEEP;
    localparam logic [PWR_W-1:0] M_IOC  = PWR_W'(1) << B_IO_CLAMP;

    // value written at step idx, and the hold time that follows it
    always_comb begin
        pwr_o  = M_PLL;
        wait_o = CNT_W'(1);
        last_o = 1'b0;
        case (idx_i)
            STEP_W'(0): begin pwr_o = M_PLL | M_L2 | M_IOC;  wait_o = CNT_W'(1);        end
            STEP_W'(1): begin pwr_o = M_PLL | M_IOC;         wait_o = CNT_W'(W_L2);     end
            STEP_W'(2): begin pwr_o = M_PLL | M_IOC | M_POR; wait_o = CNT_W'(W_POR);    end
            STEP_W'(3): begin pwr_o = M_PLL | M_POR;         wait_o = CNT_W'(W_CLAMP);  end
            STEP_W'(4): begin pwr_o = M_PLL;                 wait_o = CNT_W'(W_SETTLE); end
            default:    begin pwr_o = M_PLL | M_UP;          last_o = 1'b1;             end
        endcase
    end

endmodule

// File: rtl/core_wake_seq.sv
module core_wake_seq
    import core_wake_pkg::*;
#(
    parameter longint unsigned CLK_HZ       = 50_000_000,
    parameter logic [7:0]      RAIL_ON_CODE = 8'hA4,
    parameter longint unsigned T_RAIL_NS    = 512_000,
    parameter longint unsigned T_L2_NS      = 300,
    parameter longint unsigned T_POR_NS     = 2_000,
    parameter longint unsigned T_CLAMP_NS   = 2_000,
    parameter longint unsigned T_SETTLE_NS  = 100_000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       start,
    output logic [7:0] rail_cmd_o,
    output logic       rail_wr_o,
    output logic [8:0] pwr_ctl_o,
    output logic       busy_o,
    output logic       done_o
);

    localparam int unsigned W_RAIL   = int'(ns_to_cycles(T_RAIL_NS,   CLK_HZ));
    localparam int unsigned W_L2     = int'(ns_to_cycles(T_L2_NS,     CLK_HZ));
    localparam int unsigned W_POR    = int'(ns_to_cycles(T_POR_NS,    CLK_HZ));
    localparam int unsigned W_CLAMP  = int'(ns_to_cycles(T_CLAMP_NS,  CLK_HZ));
    localparam int unsigned W_SETTLE = int'(ns_to_cycles(T_SETTLE_NS, CLK_HZ));
    localparam int unsigned W_MAX    = max_of(max_of(W_RAIL, W_L2),
                                        max_of(max_of(W_POR, W_CLAMP), W_SETTLE));
    localparam int          CNT_W    = $clog2(W_MAX + 1);

    wk_regs_t          r_d, r_q;
    logic              tmr_load;
    logic [CNT_W-1:0]  tmr_len;
    logic              tmr_expire;
    logic [PWR_W-1:0]  tbl_pwr;
    logic [CNT_W-1:0]  tbl_wait;
    logic              tbl_last;

    wake_step_table #(
        .W_L2     (W_L2),
        .W_POR    (W_POR),
        .W_CLAMP  (W_CLAMP),
        .W_SETTLE (W_SETTLE),
        .CNT_W    (CNT_W)
    ) u_table (
        .idx_i  (r_q.step),
        .pwr_o  (tbl_pwr),
        .wait_o (tbl_wait),
        .last_o (tbl_last)
    );

    wake_delay_timer #(
        .CNT_W (CNT_W)
    ) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load_i   (tmr_load),
        .len_i    (tmr_len),
        .expire_o (tmr_expire)
    );

    always_comb begin
        r_d         = r_q;
        r_d.rail_wr = 1'b0;
        r_d.done    = 1'b0;
        tmr_load    = 1'b0;
        tmr_len     = '0;
        case (r_q.st)
            WK_IDLE: begin
                if (start) begin
                    r_d.st      = WK_RUN;
                    r_d.step    = '0;
                    r_d.rail    = RAIL_ON_CODE;
                    r_d.rail_wr = 1'b1;
                    r_d.busy    = 1'b1;
                    tmr_load    = 1'b1;
                    tmr_len     = CNT_W'(W_RAIL);
                end
            end
            WK_RUN: begin
                if (tmr_expire) begin
                    r_d.pwr = tbl_pwr;
                    if (tbl_last) begin
                        r_d.st   = WK_IDLE;
                        r_d.busy = 1'b0;
                        r_d.done = 1'b1;
                    end else begin
                        r_d.step = r_q.step + STEP_W'(1);
                        tmr_load = 1'b1;
                        tmr_len  = tbl_wait;
                    end
                end
            end
            default: r_d.st = WK_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '0;
        else     r_q <= r_d;
    end

    assign rail_cmd_o = r_q.rail;
    assign rail_wr_o  = r_q.rail_wr;
    assign pwr_ctl_o  = r_q.pwr;
    assign busy_o     = r_q.busy;
    assign done_o     = r_q.done;

    a_r2_strobe_cause: assert property (@(posedge clk) disable iff (rst)
        rail_wr_o |-> ($past(start) && !$past(busy_o)));

    a_r2_strobe_code: assert property (@(posedge clk) disable iff (rst)
        rail_wr_o |-> (rail_cmd_o == RAIL_ON_CODE && busy_o));

    a_r11_single_strobe: assert property (@(posedge clk) disable iff (rst)
        rail_wr_o |=> !rail_wr_o);

    a_r9_one_bit: assert property (@(posedge clk) disable iff (rst)
        (pwr_ctl_o != $past(pwr_ctl_o) && pwr_ctl_o != 9'h109)
            |-> ($countones(pwr_ctl_o ^ $past(pwr_ctl_o)) == 1));

    a_r9_core_rst_low: assert property (@(posedge clk) disable iff (rst)
        !pwr_ctl_o[B_CORE_RST]);

    a_r9_pll_clamp: assert property (@(posedge clk) disable iff (rst)
        (pwr_ctl_o != '0) |-> pwr_ctl_o[B_PLL_CLAMP]);

    a_r8_done_value: assert property (@(posedge clk) disable iff (rst)
        done_o |-> (pwr_ctl_o == 9'h180));

    a_r10_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    a_r10_done_not_busy: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o);

endmodule

// File: tb/sim_core_wake_seq.sv
module sim_core_wake_seq;

    // expected waits at 50 MHz, rounded up from the nanosecond figures
    localparam int E_RAIL   = (512000 * 50 + 999) / 1000;
    localparam int E_L2     = (300    * 50 + 999) / 1000;
    localparam int E_POR    = (2000   * 50 + 999) / 1000;
    localparam int E_CLAMP  = (2000   * 50 + 999) / 1000;
    localparam int E_SETTLE = (100000 * 50 + 999) / 1000;
    localparam int LIMIT    = 150000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [7:0] rail_cmd_o;
    logic       rail_wr_o;
    logic [8:0] pwr_ctl_o;
    logic       busy_o;
    logic       done_o;

    int tests = 0;
    int fails = 0;
    int cyc   = 0;

    core_wake_seq u0 (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .rail_cmd_o (rail_cmd_o),
        .rail_wr_o  (rail_wr_o),
        .pwr_ctl_o  (pwr_ctl_o),
        .busy_o     (busy_o),
        .done_o     (done_o)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    function automatic string req_of(input int v);
        case (v)
            'h109: return "R3";
            'h101: return "R4";
            'h121: return "R5";
            'h120: return "R6";
            'h100: return "R7";
            'h180: return "R8";
            default: return "R1";
        endcase
    endfunction

    // behavioural reference: queues of values and gaps, one countdown
    int m_val_q[$];
    int m_gap_q[$];
    int m_cnt  = 0;
    int m_pwr  = 0;
    int m_cmd  = 0;
    bit m_busy = 0;
    bit m_wr   = 0;
    bit m_done = 0;

    always @(posedge clk) begin
        cyc++;
        if (rst) begin
            m_val_q.delete(); m_gap_q.delete();
            m_cnt = 0; m_pwr = 0; m_cmd = 0;
            m_busy = 0; m_wr = 0; m_done = 0;
        end else begin
            m_wr = 0;
            m_done = 0;
            if (!m_busy && start) begin
                m_busy = 1; m_wr = 1; m_cmd = 'hA4;
                m_val_q = '{'h109, 'h101, 'h121, 'h120, 'h100, 'h180};
                m_gap_q = '{1, E_L2, E_POR, E_CLAMP, E_SETTLE};
                m_cnt = E_RAIL;
            end else if (m_busy) begin
                m_cnt--;
                if (m_cnt == 0) begin
                    m_pwr = m_val_q.pop_front();
                    if (m_val_q.size() == 0) begin
                        m_busy = 0; m_done = 1;
                    end else begin
                        m_cnt = m_gap_q.pop_front();
                    end
                end
            end
        end
    end

    // per-cycle comparison and gap monitor, half a cycle after each edge
    int  gaps[6] = '{E_RAIL, 1, E_L2, E_POR, E_CLAMP, E_SETTLE};
    int  last_evt = 0;
    int  gidx = 0;
    logic [8:0] prev_pwr = '0;

    always @(negedge clk) begin
        if (cyc > 0) begin
            tests++;
            if (pwr_ctl_o !== 9'(m_pwr)) begin
                fails++;
                $display("FAIL %s pwr_ctl_o: actual 0x%0h expected 0x%0h", req_of(m_pwr), pwr_ctl_o, m_pwr);
            end
            if (rail_wr_o !== m_wr || (m_wr && rail_cmd_o !== 8'(m_cmd))) begin
                fails++;
                $display("FAIL R2 rail strobe/cmd: actual %0b/0x%0h expected %0b/0x%0h", rail_wr_o, rail_cmd_o, m_wr, m_cmd);
            end
            if (busy_o !== m_busy || done_o !== m_done) begin
                fails++;
                $display("FAIL R10 busy/done: actual %0b/%0b expected %0b/%0b", busy_o, done_o, m_busy, m_done);
            end
        end
        if (!rst) begin
            if (rail_wr_o === 1'b1) begin
                last_evt = cyc; gidx = 0;
            end
            if (pwr_ctl_o !== prev_pwr) begin
                if (gidx < 6) chk((cyc - last_evt) == gaps[gidx], "R12", "gap before pwr change", cyc - last_evt, gaps[gidx]);
                last_evt = cyc; gidx++;
                if (pwr_ctl_o != 9'h109)
                    chk($countones(pwr_ctl_o ^ prev_pwr) == 1, "R9", "bits flipped", $countones(pwr_ctl_o ^ prev_pwr), 1);
                chk(pwr_ctl_o[4] == 1'b0 && pwr_ctl_o[8] == 1'b1, "R9", "core reset/pll clamp", pwr_ctl_o, pwr_ctl_o & 9'h1EF | 9'h100);
            end
        end
        prev_pwr = pwr_ctl_o;
    end

    task automatic wait_done(output bit seen);
        seen = 0;
        while (!seen && cyc < LIMIT) begin
            @(negedge clk);
            if (done_o) seen = 1;
        end
    endtask

    initial begin
        bit seen;
        repeat (3) @(negedge clk);
        chk(pwr_ctl_o == 0 && !rail_wr_o && !busy_o && !done_o, "R1", "state in reset",
            {pwr_ctl_o, rail_wr_o, busy_o, done_o}, 0);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        chk(pwr_ctl_o == 0 && !busy_o, "R1", "idle after reset", {pwr_ctl_o, busy_o}, 0);

        // first run
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(rail_wr_o == 1'b1 && rail_cmd_o == 8'hA4, "R2", "rail strobe and code", {rail_wr_o, rail_cmd_o}, 'h1A4);
        chk(busy_o == 1'b1, "R2", "busy after start", busy_o, 1);
        @(negedge clk);
        chk(rail_wr_o == 1'b0, "R2", "strobe one cycle", rail_wr_o, 0);

        repeat (1000) @(negedge clk);
        start = 1'b1;          // R11: ignored while busy
        @(negedge clk);
        start = 1'b0;
        chk(rail_wr_o == 1'b0, "R11", "no strobe while busy", rail_wr_o, 0);

        wait_done(seen);
        chk(seen, "R8", "done reached", seen, 1);
        chk(pwr_ctl_o == 9'h180 && !busy_o, "R10", "final word, busy low", {busy_o, pwr_ctl_o}, 'h180);
        @(negedge clk);
        chk(done_o == 1'b0, "R10", "done one cycle", done_o, 0);

        // second run with start held two cycles
        repeat (5) @(negedge clk);
        chk(pwr_ctl_o == 9'h180, "R13", "word held after done", pwr_ctl_o, 'h180);
        start = 1'b1;
        repeat (2) @(negedge clk);
        start = 1'b0;
        chk(rail_wr_o == 1'b0 && busy_o, "R11", "held start gives one strobe", rail_wr_o, 0);
        wait_done(seen);
        chk(seen && pwr_ctl_o == 9'h180, "R13", "second run completes", pwr_ctl_o, 'h180);
        repeat (3) @(negedge clk);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(200000 * 20);
        fails++;
        tests++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule